// File: doc/BRIEF.md
# Call-Return Shadow Stack Monitor

This block sits beside a host core and watches its stream of retired-instruction trace records. Each record carries the instruction address, the 32-bit instruction word, the resolved next PC, and a valid strobe. The monitor picks out the two RISC-V jump forms and sorts each one as a call, a return, or neither, using only the destination register field. On a call it keeps the link address on a private LIFO. On a return it takes the newest entry off the LIFO and compares it with the address the host actually jumped to.

If the saved and actual addresses differ, the monitor treats the return as a hijacked kernel control flow. It raises a sticky alarm and holds the address of the offending return instruction. A push into a full LIFO and a pop from an empty one each raise their own sticky flag, and neither one disturbs the stored entries. A single synchronous clear input drops all the sticky flags and leaves the LIFO contents as they are.

Top module: `cfr_guard`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `alarm`, `alarm_pc`, `ovf`, `unf` and `depth` are all zero.
- R2: A valid record whose opcode (bits 6:0) is 7'b1101111, or whose opcode is 7'b1100111 with bits 14:12 equal to 3'b000, and whose rd field (bits 11:7) is 1, is a call. It pushes `pc + 4`, and `depth` rises by one on the next edge.
- R3: A valid record with opcode 7'b1100111, bits 14:12 equal to 3'b000 and rd equal to 0 is a return. It pops the newest entry and `depth` falls by one. If the popped value equals `npc`, `alarm` does not change.
- R4: When a return's popped value differs from `npc`, `alarm` is 1 after the edge. `alarm_pc` takes that return's `pc` if `alarm` was clear before. `alarm` and `alarm_pc` then keep their values until a clear.
- R5: A valid jump whose rd is neither 0 nor 1, a valid JAL with rd 0, and any valid record with another opcode all leave `depth` and every flag unchanged.
- R6: A record with `vld` low has no effect on `depth` or on any output.
- R7: A call while `depth` equals DEPTH sets `ovf`, stores nothing, and leaves `depth` at DEPTH. Later returns see the entries that were stored before the stack filled.
- R8: A return while `depth` is 0 sets `unf`. It makes no comparison and leaves `alarm` and `alarm_pc` untouched.
- R9: A high `clr` zeroes `alarm`, `alarm_pc`, `ovf` and `unf` on the next edge and does not change the stack. An event in the same cycle as `clr` is still recorded.
- R10: Returns take entries back in the reverse order of the calls that pushed them, so correctly nested call and return sequences up to DEPTH deep never raise `alarm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vld | input | 1 | Trace record valid |
| pc | input | XLEN | Address of the retired instruction |
| insn | input | 32 | Retired instruction word |
| npc | input | XLEN | Resolved address of the next instruction |
| clr | input | 1 | Synchronous clear of the sticky flags |
| alarm | output | 1 | Sticky return-address mismatch flag |
| alarm_pc | output | XLEN | PC of the first mismatching return since the last clear |
| ovf | output | 1 | Sticky push-on-full flag |
| unf | output | 1 | Sticky pop-on-empty flag |
| depth | output | $clog2(DEPTH+1) | Number of entries on the shadow stack |

## Verification
Some properties can be judged from the ports one cycle apart, and the assertions check these on every cycle: the occupancy step on a call or a return, idle records, the boundary cases at full and at empty, and the holding of the alarm and its PC until a clear. Other behaviour depends on the stored contents, because the stack is deep. Whether a return matches depends on entries pushed many cycles earlier, and LIFO order only shows up after long nested sequences. Only the bench's scenarios can show this. The bench does so with random call and return streams, corrupted targets and full-depth fill and drain runs, all checked against its own reference stack.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

   typedef enum logic [1:0] {
      XK_NONE = 2'd0,
      XK_CALL = 2'd1,
      XK_RET  = 2'd2
   } xfer_kind_e;

   localparam logic [6:0] OPC_JAL  = 7'b1101111;
   localparam logic [6:0] OPC_JALR = 7'b1100111;
   localparam logic [2:0] F3_JALR  = 3'b000;
   localparam logic [4:0] REG_ZERO = 5'd0;
   localparam logic [4:0] REG_LINK = 5'd1;
   localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/cfr_decode.sv
module cfr_decode
   import cfr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            vld,
   input  logic [XLEN-1:0] pc,
   input  logic [31:0]     insn,
   output xfer_kind_e      kind,
   output logic [XLEN-1:0] link_addr
);

   logic [6:0] opc;
   logic [4:0] rd;
   logic [2:0] f3;
   logic       is_jal;
   logic       is_jalr;

   assign opc     = insn[6:0];
   assign rd      = insn[11:7];
   assign f3      = insn[14:12];
   assign is_jal  = (opc == OPC_JAL);
   assign is_jalr = (opc == OPC_JALR) && (f3 == F3_JALR);

   always_comb begin
      kind = XK_NONE;
      if (vld) begin
         if ((is_jal || is_jalr) && (rd == REG_LINK))
            kind = XK_CALL;
         else if (is_jalr && (rd == REG_ZERO))
            kind = XK_RET;
      end
   end

   assign link_addr = pc + XLEN'(INSN_BYTES);

endmodule

// File: rtl/cfr_lifo.sv
module cfr_lifo #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW   = $clog2(DEPTH + 1),
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            push,
   input  logic            pop,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] top,
   output logic [CW-1:0]   count,
   output logic            full,
   output logic            empty
);

   logic [CW-1:0]   cnt_q;
   logic [XLEN-1:0] slot [DEPTH];
   logic            do_push;
   logic            do_pop;
   logic [AW-1:0]   wr_idx;
   logic [AW-1:0]   rd_idx;
   logic [CW-1:0]   cnt_dec;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign cnt_dec = cnt_q - CW'(1);
   assign wr_idx  = AW'(cnt_q);
   assign rd_idx  = AW'(cnt_dec);

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         always_ff @(posedge clk) begin
            if (do_push && (wr_idx == AW'(gi)))
               slot[gi] <= wdata;
         end
      end
   endgenerate

   assign top = slot[rd_idx];

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (do_push)
         cnt_q <= cnt_q + CW'(1);
      else if (do_pop)
         cnt_q <= cnt_dec;
   end

   assign count = cnt_q;

endmodule

// File: rtl/cfr_judge.sv
module cfr_judge
   import cfr_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clr,
   input  xfer_kind_e      kind,
   input  logic            full,
   input  logic            empty,
   input  logic [XLEN-1:0] top,
   input  logic [XLEN-1:0] npc,
   input  logic [XLEN-1:0] pc,
   output logic            alarm,
   output logic [XLEN-1:0] alarm_pc,
   output logic            ovf,
   output logic            unf
);

   logic alarm_q, ovf_q, unf_q;
   logic [XLEN-1:0] apc_q;
   logic ev_ovf, ev_unf, ev_bad, keep;

   assign ev_ovf = (kind == XK_CALL) && full;
   assign ev_unf = (kind == XK_RET) && empty;
   assign ev_bad = (kind == XK_RET) && !empty && (top != npc);
   assign keep   = !clr;

   always_ff @(posedge clk) begin
      if (rst) begin
         alarm_q <= 1'b0;
         apc_q   <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else begin
         alarm_q <= (alarm_q && keep) || ev_bad;
         ovf_q   <= (ovf_q && keep) || ev_ovf;
         unf_q   <= (unf_q && keep) || ev_unf;
         if (ev_bad && !(alarm_q && keep))
            apc_q <= pc;
         else if (clr)
            apc_q <= '0;
      end
   end

   assign alarm    = alarm_q;
   assign alarm_pc = apc_q;
   assign ovf      = ovf_q;
   assign unf      = unf_q;

endmodule

// File: rtl/cfr_guard.sv
module cfr_guard
   import cfr_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            vld,
   input  logic [XLEN-1:0] pc,
   input  logic [31:0]     insn,
   input  logic [XLEN-1:0] npc,
   input  logic            clr,
   output logic            alarm,
   output logic [XLEN-1:0] alarm_pc,
   output logic            ovf,
   output logic            unf,
   output logic [CW-1:0]   depth
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("cfr_guard: XLEN must be 32 or 64");
      end
      if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
         $error("cfr_guard: DEPTH must lie in 2..1024");
      end
   endgenerate

   xfer_kind_e      kind;
   logic [XLEN-1:0] link_addr;
   logic [XLEN-1:0] top;
   logic            full, empty;

   cfr_decode #(.XLEN(XLEN)) u_dec (
      .vld       (vld),
      .pc        (pc),
      .insn      (insn),
      .kind      (kind),
      .link_addr (link_addr)
   );

   cfr_lifo #(.XLEN(XLEN), .DEPTH(DEPTH)) u_lifo (
      .clk   (clk),
      .rst   (rst),
      .push  (kind == XK_CALL),
      .pop   (kind == XK_RET),
      .wdata (link_addr),
      .top   (top),
      .count (depth),
      .full  (full),
      .empty (empty)
   );

   cfr_judge #(.XLEN(XLEN)) u_judge (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .kind     (kind),
      .full     (full),
      .empty    (empty),
      .top      (top),
      .npc      (npc),
      .pc       (pc),
      .alarm    (alarm),
      .alarm_pc (alarm_pc),
      .ovf      (ovf),
      .unf      (unf)
   );

endmodule

// File: rtl/cfr_guard_chk.sv
module cfr_guard_chk #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic            clk,
   input logic            rst,
   input logic            vld,
   input logic [XLEN-1:0] pc,
   input logic [31:0]     insn,
   input logic [XLEN-1:0] npc,
   input logic            clr,
   input logic            alarm,
   input logic [XLEN-1:0] alarm_pc,
   input logic            ovf,
   input logic            unf,
   input logic [CW-1:0]   depth
);

   logic c_call, c_ret, c_jump;
   assign c_jump = (insn[6:0] == 7'b1101111) ||
                   (insn[6:0] == 7'b1100111 && insn[14:12] == 3'b000);
   assign c_call = vld && c_jump && (insn[11:7] == 5'd1);
   assign c_ret  = vld && (insn[6:0] == 7'b1100111) &&
                   (insn[14:12] == 3'b000) && (insn[11:7] == 5'd0);

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (depth == '0 && !alarm && !ovf && !unf && alarm_pc == '0));

   a_r2_call_grows: assert property (@(posedge clk) disable iff (rst)
      (c_call && depth < CW'(DEPTH)) |=> (depth == $past(depth) + CW'(1)));

   a_r3_ret_shrinks: assert property (@(posedge clk) disable iff (rst)
      (c_ret && depth != '0) |=> (depth == $past(depth) - CW'(1)));

   a_r4_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
      (alarm && !clr) |=> (alarm && $stable(alarm_pc)));

   a_r5_other_no_move: assert property (@(posedge clk) disable iff (rst)
      (vld && !c_call && !c_ret) |=> $stable(depth));

   a_r6_idle_no_move: assert property (@(posedge clk) disable iff (rst)
      (!vld && !clr) |=> ($stable(depth) && $stable(alarm) && $stable(ovf) && $stable(unf)));

   a_r7_full_push: assert property (@(posedge clk) disable iff (rst)
      (c_call && depth == CW'(DEPTH)) |=> (ovf && depth == CW'(DEPTH)));

   a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
      (c_ret && depth == '0 && !clr) |=> (unf && depth == '0 && $stable(alarm) && $stable(alarm_pc)));

   a_r9_clear_quiet: assert property (@(posedge clk) disable iff (rst)
      (clr && !vld) |=> (!alarm && !ovf && !unf && alarm_pc == '0 && $stable(depth)));

   a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
      depth <= CW'(DEPTH));

endmodule

bind cfr_guard cfr_guard_chk #(.XLEN(XLEN), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst(rst), .vld(vld), .pc(pc), .insn(insn), .npc(npc),
   .clr(clr), .alarm(alarm), .alarm_pc(alarm_pc), .ovf(ovf), .unf(unf),
   .depth(depth)
);

// File: tb/sim_cfr_guard.sv
`timescale 1ns/1ps
module sim_cfr_guard;

   localparam int unsigned XLEN  = 32;
   localparam int unsigned DEPTH = 64;
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            vld = 1'b0;
   logic [XLEN-1:0] pc  = '0;
   logic [31:0]     insn = '0;
   logic [XLEN-1:0] npc = '0;
   logic            clr = 1'b0;
   logic            alarm, ovf, unf;
   logic [XLEN-1:0] alarm_pc;
   logic [CW-1:0]   depth;

   always #5 clk = ~clk;

   cfr_guard #(.XLEN(XLEN), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst(rst), .vld(vld), .pc(pc), .insn(insn), .npc(npc),
      .clr(clr), .alarm(alarm), .alarm_pc(alarm_pc), .ovf(ovf), .unf(unf),
      .depth(depth)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference model
   logic [XLEN-1:0] m_stk [DEPTH];
   int              m_cnt = 0;
   logic            m_alarm = 0, m_ovf = 0, m_unf = 0;
   logic [XLEN-1:0] m_apc = '0;

   function automatic logic [31:0] mk_jal(input logic [4:0] rd, input logic [19:0] imm);
      return {imm, rd, 7'b1101111};
   endfunction

   function automatic logic [31:0] mk_jalr(input logic [4:0] rd, input logic [4:0] rs1,
                                          input logic [11:0] imm);
      return {imm, rs1, 3'b000, rd, 7'b1100111};
   endfunction

   // 0 none, 1 call, 2 return
   function automatic int classify(input logic [31:0] w);
      logic jal_f, jalr_f;
      jal_f  = (w[6:0] == 7'b1101111);
      jalr_f = (w[6:0] == 7'b1100111) && (w[14:12] == 3'b000);
      if ((jal_f || jalr_f) && w[11:7] == 5'd1) return 1;
      if (jalr_f && w[11:7] == 5'd0) return 2;
      return 0;
   endfunction

   task automatic model_step(input logic v, input logic [XLEN-1:0] p,
                             input logic [31:0] w, input logic [XLEN-1:0] np,
                             input logic c);
      int k;
      logic nal, nov, nun;
      logic [XLEN-1:0] napc;
      nal  = m_alarm && !c;
      nov  = m_ovf && !c;
      nun  = m_unf && !c;
      napc = c ? '0 : m_apc;
      k = v ? classify(w) : 0;
      if (k == 1) begin
         if (m_cnt == DEPTH) nov = 1'b1;
         else begin m_stk[m_cnt] = p + 4; m_cnt++; end
      end else if (k == 2) begin
         if (m_cnt == 0) nun = 1'b1;
         else begin
            m_cnt--;
            if (m_stk[m_cnt] != np) begin
               if (!nal) napc = p;
               nal = 1'b1;
            end
         end
      end
      m_alarm = nal; m_ovf = nov; m_unf = nun; m_apc = napc;
   endtask

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk(tag, "depth", 64'(depth), 64'(m_cnt));
      chk(tag, "alarm", 64'(alarm), 64'(m_alarm));
      chk(tag, "alarm_pc", 64'(alarm_pc), 64'(m_apc));
      chk(tag, "ovf", 64'(ovf), 64'(m_ovf));
      chk(tag, "unf", 64'(unf), 64'(m_unf));
   endtask

   task automatic step(input string tag, input logic v, input logic [XLEN-1:0] p,
                       input logic [31:0] w, input logic [XLEN-1:0] np, input logic c);
      @(negedge clk);
      vld = v; pc = p; insn = w; npc = np; clr = c;
      model_step(v, p, w, np, c);
      @(posedge clk);
      #1;
      chk_all(tag);
   endtask

   function automatic logic [XLEN-1:0] top_of_model();
      return (m_cnt > 0) ? m_stk[m_cnt-1] : '0;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; vld = 1'b0; clr = 1'b0;
      m_cnt = 0; m_alarm = 0; m_ovf = 0; m_unf = 0; m_apc = '0;
      @(posedge clk); #1;
      chk_all("R1");
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      chk_all("R1");
   endtask

   initial begin : watchdog
      #1500000;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      logic [XLEN-1:0] a;
      seed = 32'd20240611;
      void'($urandom(seed));
      do_reset();

      // R2 / R3: call by JAL, call by JALR, matching return
      step("R2", 1, 32'h8000_1000, mk_jal(5'd1, 20'h00123), 32'h8000_2000, 0);
      step("R2", 1, 32'h8000_2010, mk_jalr(5'd1, 5'd6, 12'h040), 32'h8000_3000, 0);
      step("R3", 1, 32'h8000_3008, mk_jalr(5'd0, 5'd1, 12'h000), 32'h8000_2014, 0);
      // R5: other rd, JAL rd0, non-jump opcode
      step("R5", 1, 32'h8000_2014, mk_jalr(5'd5, 5'd1, 12'h000), 32'h8000_0000, 0);
      step("R5", 1, 32'h8000_2018, mk_jal(5'd0, 20'h00010), 32'h8000_2028, 0);
      step("R5", 1, 32'h8000_2028, 32'h0000_0013, 32'h8000_202c, 0);
      step("R5", 1, 32'h8000_202c, {12'h0, 5'd1, 3'b001, 5'd0, 7'b1100111}, 32'h0, 0);
      // R6: invalid return record with wrong target ignored
      step("R6", 0, 32'h8000_202c, mk_jalr(5'd0, 5'd1, 12'h0), 32'hdead_beef, 0);
      // R4: mismatch, then second mismatch keeps first PC
      step("R4", 1, 32'h8000_3100, mk_jalr(5'd0, 5'd1, 12'h0), 32'h1234_5678, 0);
      step("R2", 1, 32'h8000_4000, mk_jal(5'd1, 20'h1), 32'h8000_5000, 0);
      step("R4", 1, 32'h8000_5100, mk_jalr(5'd0, 5'd1, 12'h0), 32'h0bad_0bad, 0);
      // R8: pop on empty sets unf without comparing
      step("R8", 1, 32'h8000_6000, mk_jalr(5'd0, 5'd1, 12'h0), 32'h0, 0);
      // R9: quiet clear
      step("R9", 0, 32'h0, 32'h0, 32'h0, 1);
      // R9: clear together with a mismatch records the new event
      step("R2", 1, 32'h8000_7000, mk_jal(5'd1, 20'h2), 32'h8000_8000, 0);
      step("R9", 1, 32'h8000_8100, mk_jalr(5'd0, 5'd1, 12'h0), 32'h0000_0004, 1);
      step("R9", 0, 32'h0, 32'h0, 32'h0, 1);

      // R7 / R10: fill, overflow, drain in order, then underflow
      do_reset();
      for (int i = 0; i < DEPTH; i++)
         step("R10", 1, 32'h9000_0000 + 32'(i * 64), mk_jal(5'd1, 20'(i)), 32'h0, 0);
      step("R7", 1, 32'h9fff_0000, mk_jal(5'd1, 20'h7), 32'h0, 0);
      for (int i = 0; i < DEPTH; i++)
         step("R10", 1, 32'ha000_0000, mk_jalr(5'd0, 5'd1, 12'h0), top_of_model(), 0);
      step("R8", 1, 32'ha000_0004, mk_jalr(5'd0, 5'd1, 12'h0), 32'h0, 0);

      // random mix
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic c;
         r = int'($urandom_range(99));
         c = ($urandom_range(49) == 0);
         a = {$urandom(), 2'b00} ;
         if (r < 40) begin
            if ($urandom_range(1) == 0)
               step("R2", 1, a, mk_jal(5'd1, 20'($urandom())), a + 32'h100, c);
            else
               step("R2", 1, a, mk_jalr(5'd1, 5'($urandom()), 12'($urandom())), a + 32'h200, c);
         end else if (r < 78) begin
            if ($urandom_range(9) == 0)
               step("R4", 1, a, mk_jalr(5'd0, 5'd1, 12'h0), top_of_model() ^ 32'h10, c);
            else
               step("R3", 1, a, mk_jalr(5'd0, 5'd1, 12'h0), top_of_model(), c);
         end else if (r < 88) begin
            step("R5", 1, a, mk_jalr(5'($urandom_range(31, 2)), 5'd1, 12'h0), a, c);
         end else begin
            step("R6", 0, a, mk_jalr(5'd0, 5'd1, 12'h0), ~top_of_model(), c);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule